// File: doc/BRIEF.md
# Dual-Address I2C Management Target

This block is the management-bus target of a pluggable transceiver module. It watches the two-wire bus, answers two fixed 7-bit device addresses and serves a 256-byte byte-addressed space behind each one. The first space is an identification area. The host can read it, and any write to it is accepted on the bus but changes nothing. The second space is a diagnostic and control area. Its lower half carries live measurement bytes, taken from a parallel input port, together with a few host-writable control bytes. Its upper half is a window onto one of several extended pages. A page-select byte at offset 127 picks the page, and the device address stays the same.

The host frames every transfer with START and STOP. It first sends a device address and then, for a write, an offset byte followed by data bytes. A read after a repeated START continues from the offset that the last address phase left behind. Each device address keeps its own offset pointer. The pointer advances after every data byte and wraps from 255 to 0. The target drives the bus only by pulling lines low. When stretching is enabled, it holds SCL low for a fixed number of clock cycles before it returns each data byte.

Top module: `xcvr_mgmt_i2c_target`

## Requirements
- R1: A device address of 0x50 (identification space) or 0x51 (diagnostic space) is acknowledged by pulling SDA low during the ninth clock. Every other 7-bit address gets no acknowledge, and the target stays silent until the next START or STOP.
- R2: Identification offset o reads (7*o + ID_SEED) mod 256.
- R3: Writes to the identification space are acknowledged and discarded. Later reads of the written offsets return the R2 values.
- R4: In the diagnostic space, offset k with k < N_MEAS returns measurement byte k, taken from diag_meas_i bits [8k+7:8k]. The N_CTRL bytes that start at offset CTRL_BASE are writable control bytes. They reset to 0, read back what was written, and control byte j drives ctrl_o bits [8j+7:8j]. Every other lower offset except 127 reads 0. Writes to measurement and reserved offsets are ignored.
- R5: Diagnostic offset 127 is the page select. A write stores the low PAGE_W bits of the data, and a read returns the stored value zero-extended. It resets to 0. The page affects only offsets 128 to 255.
- R6: With page p selected, diagnostic offset o in 128..255 reads (3*o + 17*p + 0x5A) mod 256, and writes there are ignored.
- R7: Each device address has its own 8-bit offset pointer. The pointer is loaded by the offset byte of a write transfer, advances by one after every data byte read or written, and wraps from 255 to 0.
- R8: A repeated START followed by a read address returns data starting at the offset set by the preceding write-address phase.
- R9: Before each transmitted data byte, the target holds SCL low for exactly STRETCH_CYC clock cycles. A value of 0 disables stretching.
- R10: START is an SDA fall and STOP an SDA rise while SCL is stably high. STOP releases both lines. The target changes SDA only while SCL is low, and it never drives SDA and SCL at the same time.
- R11: A host NACK after a read byte ends the transfer. SDA stays released until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| diag_meas_i | input | N_MEAS*8 | Live measurement bytes, byte k at bits [8k+7:8k] |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| scl_oe_o | output | 1 | Pull SCL low (stretch) when 1 |
| ctrl_o | output | N_CTRL*8 | Current value of the writable control bytes |

## Verification
The bench builds the block with its default map (ten measurement bytes, two control bytes at offset 110, four extended pages) and with STRETCH_CYC set to 3, so that every returned byte is delayed by a measurable stretch. At this size the bench can sweep all 128 device addresses, read the whole identification space plus one byte past the wrap, and visit every page at its boundary with the unpaged lower half. The bench also counts the stretched cycles over a 257-byte read, which shows that the delay is applied before every byte and not only the first.

// File: rtl/xcvr_i2c_pkg.sv
package xcvr_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_REG,
        ST_RACK,
        ST_WDAT,
        ST_WACK,
        ST_STR,
        ST_TX,
        ST_TACK,
        ST_WAIT
    } tgt_st_e;

    // Identification content, derived from the offset
    function automatic logic [7:0] id_byte(input logic [7:0] off, input logic [7:0] seed);
        return (off * 8'd7) + seed;
    endfunction

    // Extended-page content, derived from offset and page
    function automatic logic [7:0] page_byte(input logic [7:0] off, input logic [7:0] page);
        return (off * 8'd3) + (page * 8'd17) + 8'h5A;
    endfunction

endpackage

// File: rtl/xcvr_i2c_sync.sv
module xcvr_i2c_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // two synchronizer stages plus one history stage per line
    logic [2:0] scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    assign scl_s     = scl_q[1];
    assign sda_s     = sda_q[1];
    assign scl_rise  = scl_q[1] & ~scl_q[2];
    assign scl_fall  = ~scl_q[1] & scl_q[2];
    // SCL must be high in both samples so simultaneous line changes are ignored
    assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

endmodule

// File: rtl/xcvr_i2c_rdmux.sv
module xcvr_i2c_rdmux #(
    parameter int         N_MEAS    = 10,
    parameter int         N_CTRL    = 2,
    parameter int         CTRL_BASE = 110,
    parameter int         PAGE_W    = 2,
    parameter logic [7:0] ID_SEED   = 8'h03
) (
    input  logic                  sel,
    input  logic [7:0]            off,
    input  logic [N_MEAS*8-1:0]   meas,
    input  logic [N_CTRL*8-1:0]   ctrl,
    input  logic [PAGE_W-1:0]     page,
    output logic [7:0]            rdata
);
    import xcvr_i2c_pkg::*;

    localparam logic [7:0] PAGE_OFF = 8'd127;

    logic [7:0] page_ext;
    logic [7:0] lower;

    assign page_ext = {{(8-PAGE_W){1'b0}}, page};

    always_comb begin
        lower = 8'h00;
        for (int k = 0; k < N_MEAS; k++) begin
            if (off == 8'(k)) lower = meas[8*k +: 8];
        end
        for (int j = 0; j < N_CTRL; j++) begin
            if (off == 8'(CTRL_BASE + j)) lower = ctrl[8*j +: 8];
        end
        if (off == PAGE_OFF) lower = page_ext;
    end

    always_comb begin
        if (!sel)        rdata = id_byte(off, ID_SEED);
        else if (off[7]) rdata = page_byte(off, page_ext);
        else             rdata = lower;
    end

endmodule

// File: rtl/xcvr_mgmt_i2c_target.sv
module xcvr_mgmt_i2c_target #(
    parameter logic [6:0] ID_ADDR     = 7'h50,
    parameter logic [6:0] DIAG_ADDR   = 7'h51,
    parameter int         N_MEAS      = 10,
    parameter int         N_CTRL      = 2,
    parameter int         CTRL_BASE   = 110,
    parameter int         PAGE_W      = 2,
    parameter logic [7:0] ID_SEED     = 8'h03,
    parameter int         STRETCH_CYC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [N_MEAS*8-1:0] diag_meas_i,
    output logic                sda_oe_o,
    output logic                scl_oe_o,
    output logic [N_CTRL*8-1:0] ctrl_o
);
    import xcvr_i2c_pkg::*;

    localparam logic [7:0] PAGE_OFF  = 8'd127;
    localparam int         SW        = (STRETCH_CYC < 2) ? 1 : $clog2(STRETCH_CYC + 1);
    localparam logic [SW-1:0] SCNT_LAST = SW'((STRETCH_CYC > 0) ? STRETCH_CYC - 1 : 0);

    typedef struct packed {
        tgt_st_e               st;
        logic [3:0]            cnt;
        logic [7:0]            sh;
        logic                  sel;
        logic                  rw;
        logic [7:0]            ptr_id;
        logic [7:0]            ptr_dg;
        logic [N_CTRL*8-1:0]   ctrl;
        logic [PAGE_W-1:0]     page;
        logic                  sda_oe;
        logic                  scl_oe;
        logic [SW-1:0]         scnt;
    } regs_t;

    regs_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] cur_ptr;
    logic [7:0] rdata;
    logic addr_hit, do_load, tx_go;

    xcvr_i2c_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign cur_ptr = q.sel ? q.ptr_dg : q.ptr_id;

    xcvr_i2c_rdmux #(
        .N_MEAS    (N_MEAS),
        .N_CTRL    (N_CTRL),
        .CTRL_BASE (CTRL_BASE),
        .PAGE_W    (PAGE_W),
        .ID_SEED   (ID_SEED)
    ) u_rdmux (
        .sel   (q.sel),
        .off   (cur_ptr),
        .meas  (diag_meas_i),
        .ctrl  (q.ctrl),
        .page  (q.page),
        .rdata (rdata)
    );

    always_comb begin
        d        = q;
        addr_hit = (q.sh[7:1] == ID_ADDR) || (q.sh[7:1] == DIAG_ADDR);
        do_load  = 1'b0;
        tx_go    = 1'b0;
        if (stop_det) begin
            d.st     = ST_IDLE;
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
        end else if (start_det) begin
            d.st     = ST_ADDR;
            d.cnt    = '0;
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_REG, ST_WDAT: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt    = '0;
                        d.sda_oe = 1'b1;
                        if (q.st == ST_ADDR) begin
                            if (addr_hit) begin
                                d.st  = ST_AACK;
                                d.sel = (q.sh[7:1] == DIAG_ADDR);
                                d.rw  = q.sh[0];
                            end else begin
                                d.st     = ST_WAIT;
                                d.sda_oe = 1'b0;
                            end
                        end else if (q.st == ST_REG) begin
                            d.st = ST_RACK;
                            if (q.sel) d.ptr_dg = q.sh;
                            else       d.ptr_id = q.sh;
                        end else begin
                            d.st = ST_WACK;
                            if (q.sel) begin
                                d.ptr_dg = q.ptr_dg + 8'd1;
                                if (q.ptr_dg == PAGE_OFF) d.page = q.sh[PAGE_W-1:0];
                                for (int j = 0; j < N_CTRL; j++) begin
                                    if (q.ptr_dg == 8'(CTRL_BASE + j)) d.ctrl[8*j +: 8] = q.sh;
                                end
                            end else begin
                                d.ptr_id = q.ptr_id + 8'd1;
                            end
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        if (q.rw) do_load = 1'b1;
                        else      d.st    = ST_REG;
                    end
                end
                ST_RACK, ST_WACK: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        d.st     = ST_WDAT;
                    end
                end
                ST_STR: begin
                    d.scnt = q.scnt + SW'(1);
                    if (q.scnt == SCNT_LAST) begin
                        d.scl_oe = 1'b0;
                        tx_go    = 1'b1;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.sda_oe = 1'b0;
                            d.cnt    = '0;
                            d.st     = ST_TACK;
                        end else begin
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.sda_oe = ~q.sh[6];
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        if (sda_s) d.st  = ST_WAIT;
                        else       d.cnt = 4'd9;
                    end else if (scl_fall && q.cnt == 4'd9) begin
                        do_load = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (do_load) begin
            if (STRETCH_CYC > 0) begin
                d.st     = ST_STR;
                d.scl_oe = 1'b1;
                d.scnt   = '0;
            end else begin
                tx_go = 1'b1;
            end
        end
        if (tx_go) begin
            d.st     = ST_TX;
            d.cnt    = '0;
            d.sh     = rdata;
            d.sda_oe = ~rdata[7];
            if (q.sel) d.ptr_dg = q.ptr_dg + 8'd1;
            else       d.ptr_id = q.ptr_id + 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o = q.sda_oe;
    assign scl_oe_o = q.scl_oe;
    assign ctrl_o   = q.ctrl;

    // consecutive stretch cycles, used only by the stretch check
    logic [15:0] str_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        str_run_q <= '0;
        else if (q.scl_oe) str_run_q <= str_run_q + 16'd1;
        else               str_run_q <= '0;
    end

    // R1
    ack_only_known_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_AACK) |-> ((q.sh[7:1] == ID_ADDR) || (q.sh[7:1] == DIAG_ADDR)));

    // R3
    id_write_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(q.ctrl) || $changed(q.page)) |-> $past(q.sel));

    // R5
    page_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(q.page) |-> ($past(q.st) == ST_WDAT) && ($past(cur_ptr) == PAGE_OFF));

    // R9
    stretch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.scl_oe |-> (str_run_q < 16'(STRETCH_CYC)));

    // R10
    sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sda_oe != $past(q.sda_oe)) |-> !$past(scl_s));

    // R10
    single_line_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.sda_oe, q.scl_oe}));

    // R10
    stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!q.sda_oe && !q.scl_oe));

endmodule

// File: tb/tb_xcvr_mgmt_i2c_target.sv
module tb_xcvr_mgmt_i2c_target;

    localparam int         N_MEAS    = 10;
    localparam int         N_CTRL    = 2;
    localparam int         CTRL_BASE = 110;
    localparam int         PAGE_W    = 2;
    localparam logic [7:0] SEED      = 8'h03;
    localparam int         STR       = 3;
    localparam int         H         = 6;
    localparam logic [6:0] A_ID      = 7'h50;
    localparam logic [6:0] A_DG      = 7'h51;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [N_MEAS*8-1:0] meas;
    logic sda_oe, scl_oe;
    logic [N_CTRL*8-1:0] ctrl;
    logic scl_line, sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int oe_cnt = 0;
    logic [7:0] rbuf [0:299];
    logic [7:0] wbuf [0:7];

    always #4 clk = ~clk;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    xcvr_mgmt_i2c_target #(
        .ID_ADDR     (A_ID),
        .DIAG_ADDR   (A_DG),
        .N_MEAS      (N_MEAS),
        .N_CTRL      (N_CTRL),
        .CTRL_BASE   (CTRL_BASE),
        .PAGE_W      (PAGE_W),
        .ID_SEED     (SEED),
        .STRETCH_CYC (STR)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_line),
        .sda_i       (sda_line),
        .diag_meas_i (meas),
        .sda_oe_o    (sda_oe),
        .scl_oe_o    (scl_oe),
        .ctrl_o      (ctrl)
    );

    always @(negedge clk) if (scl_oe) oe_cnt++;

    function automatic logic [7:0] id_exp(input int o);
        return 8'((o * 7 + int'(SEED)) % 256);
    endfunction

    function automatic logic [7:0] pg_exp(input int o, input int p);
        return 8'((o * 3 + p * 17 + 'h5A) % 256);
    endfunction

    function automatic logic [7:0] meas_exp(input int k);
        return 8'('h80 + k);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_hi();
        do tick(1); while (!scl_line);
    endtask

    task automatic clk_pulse(output logic smp);
        scl_m = 1'b1; wait_hi(); tick(H);
        smp = sda_line;
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; wait_hi(); tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; wait_hi(); tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H); clk_pulse(s);
        end
        sda_m = 1'b1; tick(H); clk_pulse(s);
        ack = !s;
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] b);
        logic s;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H); clk_pulse(s); b[i] = s;
        end
        sda_m = !mack; tick(H); clk_pulse(s);
        sda_m = 1'b1;
    endtask

    task automatic read_from(input logic [6:0] dev, input logic [7:0] off, input int n);
        logic a;
        bus_start(); put_byte({dev, 1'b0}, a); put_byte(off, a);
        bus_start(); put_byte({dev, 1'b1}, a);
        for (int i = 0; i < n; i++) get_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic read_cur(input logic [6:0] dev);
        logic a;
        bus_start(); put_byte({dev, 1'b1}, a);
        get_byte(1'b0, rbuf[0]);
        bus_stop();
    endtask

    task automatic write_to(input logic [6:0] dev, input logic [7:0] off, input int n);
        logic a;
        bus_start(); put_byte({dev, 1'b0}, a); put_byte(off, a);
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], a);
            chk("R3/R4 write data ack", 32'(a), 32'd1);
        end
        bus_stop();
    endtask

    task automatic set_ptr(input logic [6:0] dev, input logic [7:0] off);
        write_to(dev, off, 0);
    endtask

    initial begin
        for (int k = 0; k < N_MEAS; k++) meas[8*k +: 8] = meas_exp(k);
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R10 reset state
        chk("R10 reset sda_oe", 32'(sda_oe), 32'd0);
        chk("R10 reset scl_oe", 32'(scl_oe), 32'd0);
        chk("R4 reset ctrl_o", 32'(ctrl), 32'd0);

        // R1 address sweep
        for (int a = 0; a < 128; a++) begin
            logic ack;
            bus_start(); put_byte({7'(a), 1'b0}, ack); bus_stop();
            chk($sformatf("R1 ack addr %0h", a), 32'(ack),
                32'((a == 'h50) || (a == 'h51)));
            chk("R10 lines released after stop", 32'({sda_oe, scl_oe}), 32'd0);
        end

        // R5 page select resets to 0
        read_from(A_DG, 8'd127, 1);
        chk("R5 page reset value", 32'(rbuf[0]), 32'd0);

        // R2 whole identification space, R7 wrap, R9 stretch per byte
        oe_cnt = 0;
        read_from(A_ID, 8'd0, 257);
        for (int i = 0; i < 256; i++) chk($sformatf("R2 id offset %0d", i), 32'(rbuf[i]), 32'(id_exp(i)));
        chk("R7 id pointer wrap to 0", 32'(rbuf[256]), 32'(id_exp(0)));
        chk("R9 stretch cycles over 257 bytes", 32'(oe_cnt), 32'(257 * STR));
        chk("R11 sda released after nack", 32'(sda_oe), 32'd0);

        // R3 identification writes discarded, R7 pointer advance on write
        wbuf[0] = 8'h00; wbuf[1] = 8'hFF;
        write_to(A_ID, 8'd5, 2);
        read_cur(A_ID);
        chk("R7 id pointer after two writes", 32'(rbuf[0]), 32'(id_exp(7)));
        read_from(A_ID, 8'd5, 2);
        chk("R3 id offset 5 unchanged", 32'(rbuf[0]), 32'(id_exp(5)));
        chk("R3 id offset 6 unchanged", 32'(rbuf[1]), 32'(id_exp(6)));
        chk("R3 ctrl_o unchanged", 32'(ctrl), 32'd0);

        // R4 control bytes
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        write_to(A_DG, 8'(CTRL_BASE), 2);
        chk("R4 ctrl_o after write", 32'(ctrl), 32'h3CC3);
        read_from(A_DG, 8'(CTRL_BASE - 1), 4);
        chk("R4 reserved below ctrl", 32'(rbuf[0]), 32'd0);
        chk("R4 ctrl byte 0 readback", 32'(rbuf[1]), 32'hC3);
        chk("R4 ctrl byte 1 readback", 32'(rbuf[2]), 32'h3C);
        chk("R4 reserved above ctrl", 32'(rbuf[3]), 32'd0);

        // R4 measurement and reserved bytes ignore writes
        wbuf[0] = 8'h00;
        write_to(A_DG, 8'd2, 1);
        wbuf[0] = 8'hAA;
        write_to(A_DG, 8'd50, 1);
        read_from(A_DG, 8'd0, N_MEAS);
        for (int k = 0; k < N_MEAS; k++) chk($sformatf("R4 meas byte %0d", k), 32'(rbuf[k]), 32'(meas_exp(k)));
        read_from(A_DG, 8'd50, 1);
        chk("R4 reserved write ignored", 32'(rbuf[0]), 32'd0);

        // R7 separate pointers per device address
        set_ptr(A_ID, 8'd10);
        set_ptr(A_DG, 8'd3);
        read_cur(A_ID);
        chk("R7 id pointer kept", 32'(rbuf[0]), 32'(id_exp(10)));
        read_cur(A_DG);
        chk("R7 diag pointer kept", 32'(rbuf[0]), 32'(meas_exp(3)));

        // R8 repeated start read from write-address offset
        read_from(A_DG, 8'd4, 1);
        chk("R8 repeated start read", 32'(rbuf[0]), 32'(meas_exp(4)));

        // R5/R6 each page across the lower/upper boundary
        for (int p = 0; p < 4; p++) begin
            wbuf[0] = 8'hF0 | 8'(p);
            write_to(A_DG, 8'd127, 1);
            read_from(A_DG, 8'd120, 16);
            for (int i = 0; i < 7; i++) chk("R5 lower half unpaged", 32'(rbuf[i]), 32'd0);
            chk($sformatf("R5 page readback %0d", p), 32'(rbuf[7]), 32'(p));
            for (int i = 8; i < 16; i++)
                chk($sformatf("R6 page %0d offset %0d", p, 120 + i), 32'(rbuf[i]), 32'(pg_exp(120 + i, p)));
            wbuf[0] = 8'h00;
            write_to(A_DG, 8'd130, 1);
            read_from(A_DG, 8'd130, 1);
            chk("R6 upper write ignored", 32'(rbuf[0]), 32'(pg_exp(130, p)));
            read_from(A_DG, 8'd0, 1);
            chk("R5 meas unaffected by page", 32'(rbuf[0]), 32'(meas_exp(0)));
        end

        // R7 diagnostic wrap from 255 to 0 (page 3 still selected)
        read_from(A_DG, 8'd255, 2);
        chk("R7 diag offset 255", 32'(rbuf[0]), 32'(pg_exp(255, 3)));
        chk("R7 diag wrap to 0", 32'(rbuf[1]), 32'(meas_exp(0)));
        chk("R4 ctrl_o held", 32'(ctrl), 32'h3CC3);

        // R9 single byte stretch
        oe_cnt = 0;
        read_cur(A_DG);
        chk("R9 single byte stretch", 32'(oe_cnt), 32'(STR));
        chk("R11 released after final nack", 32'({sda_oe, scl_oe}), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule